// File: doc/BRIEF.md
# Page Table Refill Descriptor Engine

This block loads a two-dimensional address translation table from a chain of rectangle descriptors held in memory. Software starts a run by writing the byte address of the first descriptor to the engine's kick register. The engine then reads the descriptor words one at a time over a word-read memory port. It reads the rectangle's array of 32-bit page addresses in the same way and writes each word into the table through a write port that carries a table id, a column, a row and the data.

Each descriptor names the next one, and a next address of zero ends the chain. When the final descriptor is done the engine raises an end-of-list flag in its 8-bit interrupt status field, which software acknowledges by writing ones back. Writing zero to the kick register cancels a run in progress. Any pointer that is not on a 16-byte boundary stops the engine with an error. Only one memory read is ever outstanding.

Top module: `ptr_refill_engine`

## Requirements
- R1: After reset the engine is ready, the error flag is clear, the interrupt status field is zero, the interrupt output is low, and neither mem_req nor lut_we is asserted.
- R2: For a descriptor with corners (x0,y0) and (x1,y1), the engine makes (x1-x0+1)*(y1-y0+1) table writes in row-major order, with x advancing fastest. Write k carries the memory word at data pointer + 4*k and the table id taken from the control word.
- R3: A descriptor is five words at byte offsets 0, 4, 8, 12 and 16: the next address; {y0 in bits 31:16, x0 in bits 15:0}; {y1, x1} in the same layout; the control word (bit 0 start, bits 9:8 table id); and the data pointer.
- R4: The engine follows the next addresses in order and stops at a next address of zero. Interrupt status bit 4 (end of list) is set only after the last descriptor's final write.
- R5: A descriptor whose start bit is 0 produces no table writes, and the chain continues with its next descriptor.
- R6: A kick address, next address or data pointer whose low four bits are not zero sets the error flag and interrupt status bit 3. The engine returns to ready, makes no further table writes and does not set bit 4.
- R7: Writing zero to the kick register while a run is active stops it. No table write appears after that write, the engine returns to ready and bit 4 stays clear.
- R8: A nonzero kick while the engine is busy is ignored, and the run in progress completes unchanged.
- R9: Writing to the interrupt status register clears exactly the bits written as 1. A set from the engine in the same cycle wins. The interrupt output is the OR of the status bits under mask 0x7E.
- R10: mem_req is a one-cycle pulse, and no new request is issued while a read is outstanding.
- R11: An accepted aligned kick clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects the kick register, 1 the interrupt status register |
| reg_wr_data | input | 32 | Register write data |
| stat_ready | output | 1 | Engine idle and able to accept a kick |
| stat_err | output | 1 | Sticky error flag |
| irq_status | output | 8 | Interrupt status field: bit 4 end of list, bit 3 error |
| irq | output | 1 | Masked interrupt request |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 32 | Memory read data |
| mem_rvalid | input | 1 | Read data valid |
| lut_we | output | 1 | Table write strobe |
| lut_id | output | LID_W | Table id |
| lut_x | output | XW | Table column |
| lut_y | output | YW | Table row |
| lut_data | output | 32 | Table entry data |

## Verification
A kick is sampled on a clock edge, and mem_req follows one edge later. Each read result arrives one cycle after its request, so each descriptor word and each table entry takes three cycles, and every table write is registered one edge after its data returns. The bench never predicts those edges directly. It logs every lut_we pulse in its own write log and waits until stat_ready before it compares the log with the expected rectangle sequence. Only the abort test depends on exact timing: the bench drives the zero write in the same half cycle in which it sees the third logged write, so the expected count is exactly three.

// File: rtl/ptr_refill_pkg.sv
package ptr_refill_pkg;

    localparam int WORD_W      = 32;
    localparam int DESC_WORDS  = 5;
    localparam int WIDX_W      = $clog2(DESC_WORDS);
    localparam int IRQ_W       = 8;
    localparam int IRQ_ERR_BIT = 3;
    localparam int IRQ_LST_BIT = 4;
    localparam int CTRL_START  = 0;
    localparam int CTRL_LID_LO = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DREQ,
        ST_DWAIT,
        ST_EREQ,
        ST_EWAIT
    } fsm_e;

    typedef struct packed {
        logic [WORD_W-1:0] next;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] ctrl;
    } desc_t;

    function automatic logic on_line(input logic [WORD_W-1:0] a);
        return a[3:0] == 4'h0;
    endfunction

endpackage

// File: rtl/ptr_area_walker.sv
module ptr_area_walker #(
    parameter int XW = 8,
    parameter int YW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [XW-1:0] x0,
    input  logic [YW-1:0] y0,
    input  logic [XW-1:0] x1,
    input  logic [YW-1:0] y1,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic          last
);
    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else if (load) begin
            x_q <= x0;
            y_q <= y0;
        end else if (step) begin
            if (x_q == x1) begin
                x_q <= x0;
                y_q <= y_q + YW'(1);
            end else begin
                x_q <= x_q + XW'(1);
            end
        end
    end

    assign x    = x_q;
    assign y    = y_q;
    assign last = (x_q == x1) && (y_q == y1);

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !load && x_q == x1) |=> (x_q == $past(x0) && y_q == $past(y_q) + YW'(1))); // R2

endmodule

// File: rtl/ptr_irq_field.sv
module ptr_irq_field
    import ptr_refill_pkg::*;
#(
    parameter logic [IRQ_W-1:0] MASK = 8'h7E
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_lst,
    input  logic             set_err,
    input  logic             clr_en,
    input  logic [IRQ_W-1:0] clr_bits,
    output logic [IRQ_W-1:0] status,
    output logic             irq
);
    logic [IRQ_W-1:0] stat_q;
    logic [IRQ_W-1:0] set_v;

    always_comb begin
        set_v              = '0;
        set_v[IRQ_LST_BIT] = set_lst;
        set_v[IRQ_ERR_BIT] = set_err;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~(clr_en ? clr_bits : '0)) | set_v;
    end

    assign status = stat_q;
    assign irq    = |(stat_q & MASK);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_lst |=> status[IRQ_LST_BIT]); // R9

endmodule

// File: rtl/ptr_refill_engine.sv
module ptr_refill_engine
    import ptr_refill_pkg::*;
#(
    parameter int              XW       = 8,
    parameter int              YW       = 7,
    parameter int              LID_W    = 2,
    parameter logic [7:0]      IRQ_MASK = 8'h7E
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic             reg_wr_sel,
    input  logic [31:0]      reg_wr_data,
    output logic             stat_ready,
    output logic             stat_err,
    output logic [7:0]       irq_status,
    output logic             irq,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_rvalid,
    output logic             lut_we,
    output logic [LID_W-1:0] lut_id,
    output logic [XW-1:0]    lut_x,
    output logic [YW-1:0]    lut_y,
    output logic [31:0]      lut_data
);
    localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(DESC_WORDS - 1);

    fsm_e              state_q, state_d;
    desc_t             desc_q;
    logic [WIDX_W-1:0] widx_q, widx_d;
    logic [31:0]       daddr_q, daddr_d, eaddr_q, eaddr_d;
    logic              pend_q, pend_d, err_q, err_d;
    logic              req_q, req_d;
    logic [31:0]       maddr_q, maddr_d;
    logic              we_q, we_d;
    logic [31:0]       wdata_q;
    logic [XW-1:0]     wx_q;
    logic [YW-1:0]     wy_q;
    logic [LID_W-1:0]  wid_q;
    logic              set_lst, set_err, advance, walk_load, walk_step;
    logic              kick, abort, clr_en;
    logic [XW-1:0]     cur_x;
    logic [YW-1:0]     cur_y;
    logic              area_last;
    logic              unused_desc;

    assign kick   = reg_wr_en && !reg_wr_sel && (reg_wr_data != '0);
    assign abort  = reg_wr_en && !reg_wr_sel && (reg_wr_data == '0);
    assign clr_en = reg_wr_en && reg_wr_sel;

    ptr_area_walker #(.XW(XW), .YW(YW)) u_walk (
        .clk  (clk),
        .rst  (rst),
        .load (walk_load),
        .step (walk_step),
        .x0   (desc_q.lo[XW-1:0]),
        .y0   (desc_q.lo[16 +: YW]),
        .x1   (desc_q.hi[XW-1:0]),
        .y1   (desc_q.hi[16 +: YW]),
        .x    (cur_x),
        .y    (cur_y),
        .last (area_last)
    );

    ptr_irq_field #(.MASK(IRQ_MASK)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_lst  (set_lst),
        .set_err  (set_err),
        .clr_en   (clr_en),
        .clr_bits (reg_wr_data[7:0]),
        .status   (irq_status),
        .irq      (irq)
    );

    always_comb begin
        state_d   = state_q;
        widx_d    = widx_q;
        daddr_d   = daddr_q;
        eaddr_d   = eaddr_q;
        err_d     = err_q;
        req_d     = 1'b0;
        maddr_d   = maddr_q;
        we_d      = 1'b0;
        set_lst   = 1'b0;
        set_err   = 1'b0;
        advance   = 1'b0;
        walk_load = 1'b0;
        walk_step = 1'b0;
        unique case (state_q)
            ST_IDLE: if (kick) begin
                if (on_line(reg_wr_data)) begin
                    daddr_d = reg_wr_data;
                    widx_d  = '0;
                    err_d   = 1'b0;
                    state_d = ST_DREQ;
                end else begin
                    err_d   = 1'b1;
                    set_err = 1'b1;
                end
            end
            ST_DREQ: if (!pend_q) begin
                req_d   = 1'b1;
                maddr_d = daddr_q + {{(30-WIDX_W){1'b0}}, widx_q, 2'b00};
                state_d = ST_DWAIT;
            end
            ST_DWAIT: if (mem_rvalid) begin
                if (widx_q != WIDX_LAST) begin
                    widx_d  = widx_q + WIDX_W'(1);
                    state_d = ST_DREQ;
                end else if (!on_line(mem_rdata)) begin
                    err_d   = 1'b1;
                    set_err = 1'b1;
                    state_d = ST_IDLE;
                end else if (!desc_q.ctrl[CTRL_START]) begin
                    advance = 1'b1;
                end else begin
                    walk_load = 1'b1;
                    eaddr_d   = mem_rdata;
                    state_d   = ST_EREQ;
                end
            end
            ST_EREQ: begin
                req_d   = 1'b1;
                maddr_d = eaddr_q;
                state_d = ST_EWAIT;
            end
            ST_EWAIT: if (mem_rvalid) begin
                we_d    = 1'b1;
                eaddr_d = eaddr_q + 32'd4;
                if (area_last) advance = 1'b1;
                else begin
                    walk_step = 1'b1;
                    state_d   = ST_EREQ;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (advance) begin
            if (desc_q.next == '0) begin
                set_lst = 1'b1;
                state_d = ST_IDLE;
            end else if (!on_line(desc_q.next)) begin
                err_d   = 1'b1;
                set_err = 1'b1;
                state_d = ST_IDLE;
            end else begin
                daddr_d = desc_q.next;
                widx_d  = '0;
                state_d = ST_DREQ;
            end
        end
        if (abort && state_q != ST_IDLE) begin
            state_d = ST_IDLE;
            req_d   = 1'b0;
            we_d    = 1'b0;
            set_lst = 1'b0;
        end
        pend_d = (pend_q && !mem_rvalid) || req_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            desc_q  <= '0;
            widx_q  <= '0;
            daddr_q <= '0;
            eaddr_q <= '0;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
            req_q   <= 1'b0;
            maddr_q <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            wx_q    <= '0;
            wy_q    <= '0;
            wid_q   <= '0;
        end else begin
            state_q <= state_d;
            widx_q  <= widx_d;
            daddr_q <= daddr_d;
            eaddr_q <= eaddr_d;
            pend_q  <= pend_d;
            err_q   <= err_d;
            req_q   <= req_d;
            maddr_q <= maddr_d;
            we_q    <= we_d;
            if (state_q == ST_DWAIT && mem_rvalid) begin
                case (widx_q)
                    WIDX_W'(0): desc_q.next <= mem_rdata;
                    WIDX_W'(1): desc_q.lo   <= mem_rdata;
                    WIDX_W'(2): desc_q.hi   <= mem_rdata;
                    WIDX_W'(3): desc_q.ctrl <= mem_rdata;
                    default: ;
                endcase
            end
            if (we_d) begin
                wdata_q <= mem_rdata;
                wx_q    <= cur_x;
                wy_q    <= cur_y;
                wid_q   <= desc_q.ctrl[CTRL_LID_LO +: LID_W];
            end
        end
    end

    assign unused_desc = ^desc_q;

    assign stat_ready = (state_q == ST_IDLE);
    assign stat_err   = err_q;
    assign mem_req    = req_q;
    assign mem_addr   = maddr_q;
    assign lut_we     = we_q;
    assign lut_data   = wdata_q;
    assign lut_x      = wx_q;
    assign lut_y      = wy_q;
    assign lut_id     = wid_q;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R10
    AST_WE_FROM_READ: assert property (@(posedge clk) disable iff (rst)
        lut_we |-> $past(mem_rvalid)); // R2
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (stat_ready && $past(stat_ready)) |-> !lut_we); // R7
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_err) |-> stat_ready); // R6

endmodule

// File: tb/test_ptr_refill_engine.sv
`timescale 1ns/1ps
module test_ptr_refill_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        stat_ready, stat_err, irq, mem_req, mem_rvalid, lut_we;
    logic [7:0]  irq_status;
    logic [31:0] mem_addr, mem_rdata, lut_data;
    logic [1:0]  lut_id;
    logic [7:0]  lut_x;
    logic [6:0]  lut_y;

    int errors = 0, checks = 0;
    int wr_cnt = 0, viol = 0;
    bit outst = 1'b0;
    logic [31:0] mem [0:255];
    logic [31:0] log_d  [0:255];
    logic [7:0]  log_x  [0:255];
    logic [6:0]  log_y  [0:255];
    logic [1:0]  log_id [0:255];

    always #2.5 clk = ~clk;

    ptr_refill_engine i_ptr_refill_engine (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .stat_ready(stat_ready), .stat_err(stat_err),
        .irq_status(irq_status), .irq(irq), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .lut_we(lut_we),
        .lut_id(lut_id), .lut_x(lut_x), .lut_y(lut_y), .lut_data(lut_data)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem[mem_addr[9:2]];
    end

    // table write log
    always @(posedge clk) begin
        if (!rst && lut_we) begin
            log_d[wr_cnt % 256]  <= lut_data;
            log_x[wr_cnt % 256]  <= lut_x;
            log_y[wr_cnt % 256]  <= lut_y;
            log_id[wr_cnt % 256] <= lut_id;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // outstanding-read monitor for R10
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rvalid) outst = 1'b0;
            if (mem_req) begin
                if (outst) viol++;
                outst = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!stat_ready && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
        if (n >= 5000) chk(1'b0, "ready-timeout", 32'h0, 32'h1);
    endtask

    task automatic put_desc(input int a, input logic [31:0] nxt, input int x0, input int y0,
                            input int x1, input int y1, input bit st, input int lid, input logic [31:0] dp);
        mem[a/4]     = nxt;
        mem[a/4 + 1] = {16'(y0), 16'(x0)};
        mem[a/4 + 2] = {16'(y1), 16'(x1)};
        mem[a/4 + 3] = {22'd0, 2'(lid), 7'd0, st};
        mem[a/4 + 4] = dp;
    endtask

    task automatic put_data(input int dp, input int n, input logic [31:0] seed);
        for (int k = 0; k < n; k++) mem[dp/4 + k] = seed + 32'(k);
    endtask

    task automatic expect_area(input int base, input int x0, input int y0, input int x1, input int y1,
                               input int lid, input logic [31:0] seed, input string req);
        int k = 0;
        for (int yy = y0; yy <= y1; yy++)
            for (int xx = x0; xx <= x1; xx++) begin
                int i = (base + k) % 256;
                chk(log_x[i] == 8'(xx) && log_y[i] == 7'(yy) && log_id[i] == 2'(lid)
                    && log_d[i] == seed + 32'(k), req, log_d[i], seed + 32'(k));
                k++;
            end
    endtask

    // {x0, y0, x1, y1, lut id}
    localparam logic [39:0] VEC [4] = '{
        {8'd0,   8'd0,   8'd0,   8'd0,   8'd0},
        {8'd5,   8'd10,  8'd7,   8'd11,  8'd1},
        {8'd255, 8'd124, 8'd255, 8'd127, 8'd2},
        {8'd252, 8'd127, 8'd255, 8'd127, 8'd3}
    };

    initial begin
        int base, cnt;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(stat_ready && !stat_err, "R1 ready/err", {stat_ready, stat_err}, 32'h2);
        chk(irq_status == 8'h00 && !irq, "R1 irq", {irq_status, irq}, 32'h0);
        chk(!mem_req && !lut_we, "R1 idle ports", {mem_req, lut_we}, 32'h0);

        // table of single-descriptor runs (R2, R3)
        for (int v = 0; v < 4; v++) begin
            int x0 = int'(VEC[v][39:32]), y0 = int'(VEC[v][31:24]);
            int x1 = int'(VEC[v][23:16]), y1 = int'(VEC[v][15:8]);
            int lid = int'(VEC[v][7:0]);
            logic [31:0] seed = 32'hA000_0000 + 32'(v << 8);
            cnt  = (x1 - x0 + 1) * (y1 - y0 + 1);
            put_desc(32'h40, 32'h0, x0, y0, x1, y1, 1'b1, lid, 32'h200);
            put_data(32'h200, cnt, seed);
            base = wr_cnt;
            reg_write(1'b0, 32'h40);
            wait_ready();
            chk(wr_cnt - base == cnt, "R2 entry count", 32'(wr_cnt - base), 32'(cnt));
            expect_area(base, x0, y0, x1, y1, lid, seed, "R3 R2 area order/data");
            chk(irq_status[4] && irq, "R4 end of list", {irq_status, irq}, 32'h21);
            reg_write(1'b1, 32'h10);
            chk(irq_status == 8'h0 && !irq, "R9 w1c clear", irq_status, 32'h0);
        end

        // chain of two (R4)
        put_desc(32'h40, 32'h80, 0, 0, 1, 0, 1'b1, 0, 32'h200);
        put_desc(32'h80, 32'h0, 3, 3, 3, 4, 1'b1, 1, 32'h300);
        put_data(32'h200, 2, 32'h1111_0000);
        put_data(32'h300, 2, 32'h2222_0000);
        base = wr_cnt;
        reg_write(1'b0, 32'h40);
        while (wr_cnt - base < 2) @(negedge clk);
        chk(!irq_status[4], "R4 no lst mid-chain", irq_status, 32'h0);
        wait_ready();
        chk(wr_cnt - base == 4, "R4 chain count", 32'(wr_cnt - base), 32'd4);
        expect_area(base, 0, 0, 1, 0, 0, 32'h1111_0000, "R4 first desc");
        expect_area(base + 2, 3, 3, 3, 4, 1, 32'h2222_0000, "R4 second desc");
        // partial w1c (R9): writing only bit 3 keeps bit 4
        reg_write(1'b1, 32'h08);
        chk(irq_status[4], "R9 partial w1c", irq_status, 32'h10);
        reg_write(1'b1, 32'h10);

        // start bit clear skips (R5)
        put_desc(32'h40, 32'h80, 0, 0, 2, 2, 1'b0, 0, 32'h200);
        put_desc(32'h80, 32'h0, 9, 9, 9, 9, 1'b1, 2, 32'h300);
        base = wr_cnt;
        reg_write(1'b0, 32'h40);
        wait_ready();
        chk(wr_cnt - base == 1, "R5 skip count", 32'(wr_cnt - base), 32'd1);
        expect_area(base, 9, 9, 9, 9, 2, 32'h2222_0000, "R5 skip data");
        reg_write(1'b1, 32'hFF);

        // misaligned kick (R6)
        base = wr_cnt;
        reg_write(1'b0, 32'h44);
        repeat (20) @(negedge clk);
        chk(stat_err && stat_ready && wr_cnt == base, "R6 bad kick", {stat_err, stat_ready}, 32'h3);
        chk(irq_status == 8'h08 && irq, "R6 err irq", irq_status, 32'h08);
        reg_write(1'b1, 32'h08);

        // misaligned data pointer (R6) after a good kick clears err (R11)
        put_desc(32'h40, 32'h0, 0, 0, 1, 1, 1'b1, 0, 32'h204);
        base = wr_cnt;
        reg_write(1'b0, 32'h40);
        chk(!stat_err, "R11 err cleared", stat_err, 32'h0);
        wait_ready();
        chk(stat_err && wr_cnt == base && !irq_status[4], "R6 bad data ptr", 32'(wr_cnt - base), 32'h0);
        reg_write(1'b1, 32'hFF);

        // misaligned next address (R6)
        put_desc(32'h40, 32'h88, 1, 1, 1, 1, 1'b1, 3, 32'h200);
        base = wr_cnt;
        reg_write(1'b0, 32'h40);
        wait_ready();
        chk(stat_err && wr_cnt - base == 1, "R6 bad next", 32'(wr_cnt - base), 32'd1);
        chk(irq_status == 8'h08, "R6 no lst on error", irq_status, 32'h08);
        reg_write(1'b1, 32'hFF);

        // abort (R7)
        put_desc(32'h40, 32'h0, 0, 0, 7, 3, 1'b1, 0, 32'h200);
        put_data(32'h200, 32, 32'h3333_0000);
        base = wr_cnt;
        reg_write(1'b0, 32'h40);
        while (wr_cnt - base < 3) @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = 32'h0;
        @(negedge clk);
        reg_wr_en = 1'b0;
        repeat (20) @(negedge clk);
        chk(wr_cnt - base == 3, "R7 abort count", 32'(wr_cnt - base), 32'd3);
        chk(stat_ready && !irq_status[4], "R7 abort idle", {stat_ready, irq_status}, 32'h100);

        // busy kick ignored (R8)
        put_desc(32'h40, 32'h0, 2, 2, 3, 3, 1'b1, 1, 32'h200);
        put_desc(32'h80, 32'h0, 6, 6, 6, 6, 1'b1, 3, 32'h300);
        put_data(32'h200, 4, 32'h4444_0000);
        base = wr_cnt;
        reg_write(1'b0, 32'h40);
        repeat (2) @(negedge clk);
        reg_write(1'b0, 32'h80);
        wait_ready();
        chk(wr_cnt - base == 4, "R8 busy kick count", 32'(wr_cnt - base), 32'd4);
        expect_area(base, 2, 2, 3, 3, 1, 32'h4444_0000, "R8 busy kick data");
        reg_write(1'b1, 32'hFF);

        chk(viol == 0, "R10 one outstanding read", 32'(viol), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule